// File: doc/BRIEF.md
# PATA PIO Strobe Timing Sequencer

This block produces the read/write strobe timing for a two-channel parallel ATA interface running programmed I/O. Every count is in cycles of the host bus clock (nominally 33 MHz, about 30 ns per count). Each access goes through three phases: an address-setup phase, a strobe-active phase and a recovery phase. The lengths of these phases come from timing bytes and setup codes that a simple configuration write port loads. Each timing byte packs an active count in its upper nibble and a recovery count in its lower nibble.

The primary channel has a timing byte and a setup code for each drive. On the secondary channel both drives share one setup code and one live active/recovery register. The block keeps a saved timing byte for each secondary drive. It copies the saved byte into the shared register when an access selects a drive other than the one served last. After reset no drive counts as served last, so the first secondary access always triggers a copy. Per-channel interrupt-pending flags capture the drive interrupt lines until they are acknowledged.

Access requests arrive on a valid/ready stream. `req_ready` is high only while the sequencer is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. A requester that sees `req_ready` low must hold `req_valid`, `req_chan` and `req_drive` steady until the request is taken. The block itself never stalls inside a cycle. It pulses `cyc_done` in the last recovery clock and raises `req_ready` again on the next clock.

Top module: `pio_strobe_timer`

## Requirements
- R1: After reset, `req_ready` is 1, and `chan_strobe`, `cyc_done` and `irq_pend` are 0. Every timing byte, including the shared secondary register, resets to 8'h0F, and every setup code resets to 2'b11. The first access on either channel therefore takes 5 setup, 16 active and 16 recovery clocks.
- R2: The setup phase starts on the clock after acceptance and lasts for the setup code's clock count: 2'b01 gives 2, 2'b10 gives 3, 2'b00 gives 4 and 2'b11 gives 5 (the `SETUP_LONG_CLKS` parameter). `cyc_busy` is high and no strobe is high during this phase.
- R3: `chan_strobe[req_chan]` is then high for a clocks, where a is timing byte bits [7:4], except that a field of 0 gives 16 clocks.
- R4: Recovery follows for r+1 clocks with the strobe low, where r is timing byte bits [3:0]. `cyc_done` is high for exactly the last recovery clock.
- R5: `req_ready` is low from acceptance until `cyc_done` and high on the clock after it. At most one `chan_strobe` bit is high, and it is the bit of the requested channel. `cyc_drive` shows the requested drive while the cycle runs.
- R6: A configuration write with `cfg_chan`=0 and `cfg_kind`=0 loads the timing byte `cfg_data` for drive `cfg_drive`. With `cfg_kind`=1 it loads the setup code from `cfg_data[7:6]`. The two primary drives keep independent values.
- R7: A setup-code write with `cfg_chan`=1 updates the single secondary setup code whatever `cfg_drive` is, and both secondary drives use it.
- R8: A timing write with `cfg_chan`=1 updates the saved byte of `cfg_drive`. A secondary access to a drive other than the last one served, or the first secondary access after reset, copies that drive's saved byte into the shared register and times the cycle from it.
- R9: Rewriting the saved byte of the secondary drive served last does not change that drive's cycles. The new value is used only after an access to the other drive has come in between.
- R10: A configuration write made during a cycle does not change the phase lengths of that cycle.
- R11: `irq_pend[c]` is set on the clock after `dev_irq[c]` is seen high, stays set until `irq_ack[c]` is seen, and is cleared by that acknowledge. When set and acknowledge arrive on the same clock, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock that all phase counts use |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | 1 | Channel addressed by the write (0 primary, 1 secondary) |
| cfg_drive | input | 1 | Drive addressed by the write |
| cfg_kind | input | 1 | 0 writes a timing byte, 1 writes a setup code |
| cfg_data | input | 8 | Timing byte, or setup code in bits [7:6] |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_chan | input | 1 | Channel of the requested access |
| req_drive | input | 1 | Drive of the requested access |
| chan_strobe | output | 2 | Per-channel strobe, high during the active phase |
| cyc_busy | output | 1 | A cycle is in its setup, active or recovery phase |
| cyc_drive | output | 1 | Drive of the cycle in progress |
| cyc_done | output | 1 | One-clock pulse in the last recovery clock |
| dev_irq | input | 2 | Interrupt lines from each channel's drives |
| irq_ack | input | 2 | Per-channel interrupt acknowledge |
| irq_pend | output | 2 | Per-channel sticky interrupt-pending flag |

## Verification
Some properties are checked on every clock: only one strobe bit is high at a time, `req_ready` and a running cycle never overlap, `req_ready` returns after `cyc_done`, strobe pulses never exceed 16 clocks and are always preceded by at least two setup clocks, the shared register copy happens only on a secondary acceptance and always on the first one after reset, and a pending flag persists until acknowledged. The exact phase lengths depend on the packed encodings and on which secondary drive was served last. Those lengths, the stale value left in the shared register, and the insulation of a running cycle from a mid-cycle write can only be shown by the bench's scenarios, which compare measured lengths against a reference model.

// File: rtl/pio_tim_pkg.sv
package pio_tim_pkg;
  localparam int NUM_CH  = 2;
  localparam int NUM_DRV = 2;
  localparam int BYTE_W  = 8;
  localparam int MAX_CLKS = 16;
  localparam int CNT_W   = $clog2(MAX_CLKS + 1);

  localparam logic [BYTE_W-1:0] TIM_RESET = 8'h0F;
  localparam logic [1:0]        SU_RESET  = 2'b11;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_ACT   = 2'd2,
    PH_REC   = 2'd3
  } phase_t;

  // active nibble: zero stands for the maximum length
  function automatic logic [CNT_W-1:0] act_clks(input logic [BYTE_W-1:0] b);
    logic [CNT_W-1:0] v;
    v = {{(CNT_W-4){1'b0}}, b[7:4]};
    if (b[7:4] == 4'd0) v = CNT_W'(MAX_CLKS);
    return v;
  endfunction

  // recovery nibble is stored as clocks minus one
  function automatic logic [CNT_W-1:0] rec_clks(input logic [BYTE_W-1:0] b);
    return {{(CNT_W-4){1'b0}}, b[3:0]} + CNT_W'(1);
  endfunction

  // setup code ordering is not monotonic in its binary value
  function automatic logic [CNT_W-1:0] setup_clks(input logic [1:0] code,
                                                  input logic [CNT_W-1:0] longest);
    logic [CNT_W-1:0] v;
    case (code)
      2'b01:   v = CNT_W'(2);
      2'b10:   v = CNT_W'(3);
      2'b00:   v = CNT_W'(4);
      default: v = longest;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs
  import pio_tim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_chan,
  input  logic              cfg_drive,
  input  logic              cfg_kind,
  input  logic [BYTE_W-1:0] cfg_data,
  input  logic              acc_fire,
  input  logic              acc_chan,
  input  logic              acc_drive,
  output logic [BYTE_W-1:0] sel_tim,
  output logic [1:0]        sel_su,
  output logic              sec_reload
);
  logic [BYTE_W-1:0] pri_tim [NUM_DRV];
  logic [1:0]        pri_su  [NUM_DRV];
  logic [BYTE_W-1:0] sec_save [NUM_DRV];
  logic [BYTE_W-1:0] sec_live;
  logic [1:0]        sec_su;
  logic              last_vld;
  logic              last_drv;

  logic wr_tim, wr_su;
  assign wr_tim = cfg_we && !cfg_kind;
  assign wr_su  = cfg_we &&  cfg_kind;

  genvar g;
  generate
    for (g = 0; g < NUM_DRV; g++) begin : g_drv
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pri_tim[g]  <= TIM_RESET;
          pri_su[g]   <= SU_RESET;
          sec_save[g] <= TIM_RESET;
        end else begin
          if (wr_tim && !cfg_chan && cfg_drive == 1'(g)) pri_tim[g]  <= cfg_data;
          if (wr_su  && !cfg_chan && cfg_drive == 1'(g)) pri_su[g]   <= cfg_data[7:6];
          if (wr_tim &&  cfg_chan && cfg_drive == 1'(g)) sec_save[g] <= cfg_data;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) sec_su <= SU_RESET;
    else if (wr_su && cfg_chan) sec_su <= cfg_data[7:6];
  end

  logic drv_changed;
  assign drv_changed = !last_vld || (last_drv != acc_drive);
  assign sec_reload  = acc_fire && acc_chan && drv_changed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_live <= TIM_RESET;
      last_vld <= 1'b0;
      last_drv <= 1'b0;
    end else if (sec_reload) begin
      sec_live <= sec_save[acc_drive];
      last_vld <= 1'b1;
      last_drv <= acc_drive;
    end
  end

  always_comb begin
    if (!acc_chan) begin
      sel_tim = pri_tim[acc_drive];
      sel_su  = pri_su[acc_drive];
    end else begin
      sel_tim = drv_changed ? sec_save[acc_drive] : sec_live;
      sel_su  = sec_su;
    end
  end
endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
  import pio_tim_pkg::*;
#(
  parameter int SETUP_LONG_CLKS = 5
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_chan,
  input  logic              req_drive,
  input  logic [BYTE_W-1:0] tim_byte,
  input  logic [1:0]        su_code,
  output logic              req_ready,
  output logic              acc_fire,
  output logic [NUM_CH-1:0] chan_strobe,
  output logic              cyc_busy,
  output logic              cyc_drive,
  output logic              cyc_done
);
  localparam logic [CNT_W-1:0] LONG_C = CNT_W'(SETUP_LONG_CLKS);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] act_q, rec_q;
  logic             chan_q, drv_q;
  logic             last_clk;

  assign req_ready = (phase == PH_IDLE);
  assign acc_fire  = req_valid && req_ready;
  assign last_clk  = (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      act_q  <= '0;
      rec_q  <= '0;
      chan_q <= 1'b0;
      drv_q  <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (acc_fire) begin
          phase  <= PH_SETUP;
          cnt    <= setup_clks(su_code, LONG_C);
          act_q  <= act_clks(tim_byte);
          rec_q  <= rec_clks(tim_byte);
          chan_q <= req_chan;
          drv_q  <= req_drive;
        end
        PH_SETUP: if (last_clk) begin
          phase <= PH_ACT;
          cnt   <= act_q;
        end else cnt <= cnt - CNT_W'(1);
        PH_ACT: if (last_clk) begin
          phase <= PH_REC;
          cnt   <= rec_q;
        end else cnt <= cnt - CNT_W'(1);
        default: if (last_clk) begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end else cnt <= cnt - CNT_W'(1);
      endcase
    end
  end

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_stb
      assign chan_strobe[c] = (phase == PH_ACT) && (chan_q == 1'(c));
    end
  endgenerate

  assign cyc_busy  = (phase != PH_IDLE);
  assign cyc_drive = drv_q;
  assign cyc_done  = (phase == PH_REC) && last_clk;
endmodule

// File: rtl/pio_irq_flags.sv
module pio_irq_flags
  import pio_tim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] dev_irq,
  input  logic [NUM_CH-1:0] irq_ack,
  output logic [NUM_CH-1:0] irq_pend
);
  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      always_ff @(posedge clk) begin
        if (!rst_n)          irq_pend[c] <= 1'b0;
        else if (dev_irq[c]) irq_pend[c] <= 1'b1;
        else if (irq_ack[c]) irq_pend[c] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/pio_strobe_timer.sv
module pio_strobe_timer
  import pio_tim_pkg::*;
#(
  parameter int SETUP_LONG_CLKS = 5
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_chan,
  input  logic        cfg_drive,
  input  logic        cfg_kind,
  input  logic [7:0]  cfg_data,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_chan,
  input  logic        req_drive,
  output logic [1:0]  chan_strobe,
  output logic        cyc_busy,
  output logic        cyc_drive,
  output logic        cyc_done,
  input  logic [1:0]  dev_irq,
  input  logic [1:0]  irq_ack,
  output logic [1:0]  irq_pend
);
  logic [BYTE_W-1:0] sel_tim;
  logic [1:0]        sel_su;
  logic              acc_fire;
  logic              sec_reload;

  pio_timing_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_chan   (cfg_chan),
    .cfg_drive  (cfg_drive),
    .cfg_kind   (cfg_kind),
    .cfg_data   (cfg_data),
    .acc_fire   (acc_fire),
    .acc_chan   (req_chan),
    .acc_drive  (req_drive),
    .sel_tim    (sel_tim),
    .sel_su     (sel_su),
    .sec_reload (sec_reload)
  );

  pio_phase_seq #(.SETUP_LONG_CLKS(SETUP_LONG_CLKS)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_chan    (req_chan),
    .req_drive   (req_drive),
    .tim_byte    (sel_tim),
    .su_code     (sel_su),
    .req_ready   (req_ready),
    .acc_fire    (acc_fire),
    .chan_strobe (chan_strobe),
    .cyc_busy    (cyc_busy),
    .cyc_drive   (cyc_drive),
    .cyc_done    (cyc_done)
  );

  pio_irq_flags u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_irq  (dev_irq),
    .irq_ack  (irq_ack),
    .irq_pend (irq_pend)
  );
endmodule

// File: rtl/pio_strobe_timer_chk.sv
module pio_strobe_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_chan,
  input logic [1:0] chan_strobe,
  input logic       cyc_busy,
  input logic       cyc_done,
  input logic [1:0] irq_ack,
  input logic [1:0] irq_pend,
  input logic       sec_reload
);
  logic [4:0] act_run;
  logic       sec_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_run  <= '0;
      sec_seen <= 1'b0;
    end else begin
      act_run <= (|chan_strobe) ? act_run + 5'd1 : 5'd0;
      if (req_valid && req_ready && req_chan) sec_seen <= 1'b1;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_strobe)); // R5
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_busy |-> !req_ready); // R5
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> req_ready); // R4
  AST_ACTIVE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_strobe) |-> (act_run < 5'd16)); // R3
  AST_SETUP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|chan_strobe) |-> ($past(cyc_busy) && $past(cyc_busy, 2))); // R2
  AST_RELOAD_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    sec_reload |-> (req_valid && req_ready && req_chan)); // R8
  AST_RELOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_chan && !sec_seen) |-> sec_reload); // R8
  AST_IRQ_HOLD0: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend[0] && !irq_ack[0]) |=> irq_pend[0]); // R11
  AST_IRQ_HOLD1: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend[1] && !irq_ack[1]) |=> irq_pend[1]); // R11
endmodule

bind pio_strobe_timer pio_strobe_timer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_chan    (req_chan),
  .chan_strobe (chan_strobe),
  .cyc_busy    (cyc_busy),
  .cyc_done    (cyc_done),
  .irq_ack     (irq_ack),
  .irq_pend    (irq_pend),
  .sec_reload  (sec_reload)
);

// File: tb/sim_pio_strobe_timer.sv
module sim_pio_strobe_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_chan = 0, cfg_drive = 0, cfg_kind = 0;
  logic [7:0] cfg_data = 0;
  logic req_valid = 0, req_chan = 0, req_drive = 0;
  logic req_ready, cyc_busy, cyc_drive, cyc_done;
  logic [1:0] chan_strobe, irq_pend;
  logic [1:0] dev_irq = 0, irq_ack = 0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pio_strobe_timer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
    .cfg_drive(cfg_drive), .cfg_kind(cfg_kind), .cfg_data(cfg_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
    .req_drive(req_drive), .chan_strobe(chan_strobe), .cyc_busy(cyc_busy),
    .cyc_drive(cyc_drive), .cyc_done(cyc_done), .dev_irq(dev_irq),
    .irq_ack(irq_ack), .irq_pend(irq_pend)
  );

  // reference model of the programmed values
  logic [7:0] m_pt [2];
  logic [1:0] m_ps [2];
  logic [7:0] m_ss [2];
  logic [7:0] m_live;
  logic [1:0] m_su;
  bit         m_lv;
  bit         m_ld;

  function automatic int f_setup(input logic [1:0] c);
    case (c)
      2'b01: return 2;
      2'b10: return 3;
      2'b00: return 4;
      default: return 5;
    endcase
  endfunction
  function automatic int f_act(input logic [7:0] b);
    return (b[7:4] == 0) ? 16 : int'(b[7:4]);
  endfunction
  function automatic int f_rec(input logic [7:0] b);
    return int'(b[3:0]) + 1;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_pt[i] = 8'h0F; m_ps[i] = 2'b11; m_ss[i] = 8'h0F;
    end
    m_live = 8'h0F; m_su = 2'b11; m_lv = 0; m_ld = 0;
  endtask

  task automatic cfg_write(input bit c, input bit d, input bit k, input logic [7:0] v);
    cfg_we = 1; cfg_chan = c; cfg_drive = d; cfg_kind = k; cfg_data = v;
    @(negedge clk);
    cfg_we = 0;
    if (!c && !k) m_pt[d] = v;
    if (!c &&  k) m_ps[d] = v[7:6];
    if ( c && !k) m_ss[d] = v;
    if ( c &&  k) m_su = v[7:6];
  endtask

  task automatic do_access(input bit c, input bit d, input string tag,
                           input bit mid, input logic [7:0] mid_v);
    int es, ea, er, s, a, r, n;
    bit seen, other, drv_ok, rdy_low;
    logic [7:0] t;
    logic [1:0] su;
    if (!c) begin
      t = m_pt[d]; su = m_ps[d];
    end else begin
      if (!m_lv || m_ld != d) begin
        m_live = m_ss[d]; m_lv = 1; m_ld = d;
      end
      t = m_live; su = m_su;
    end
    es = f_setup(su); ea = f_act(t); er = f_rec(t);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_chan = c; req_drive = d;
    @(negedge clk);
    req_valid = 0;
    s = 0; a = 0; r = 0; n = 0; seen = 0; other = 0;
    drv_ok = (cyc_drive == d); rdy_low = !req_ready;
    fork
      begin
        while (n < 80) begin
          n++;
          if (chan_strobe[c]) begin a++; seen = 1; end
          else if (!seen) s++;
          else r++;
          if (chan_strobe[!c]) other = 1;
          if (cyc_done) break;
          @(negedge clk);
        end
      end
      begin
        if (mid) begin
          @(negedge clk);
          cfg_write(c, d, 1'b0, mid_v);
        end
      end
    join
    chk(s == es, {"R2 setup length ", tag}, s, es);
    chk(a == ea, {"R3 active length ", tag}, a, ea);
    chk(r == er, {"R4 recovery length ", tag}, r, er);
    chk(!other && drv_ok && rdy_low, {"R5 strobe channel/drive/ready ", tag},
        {other, drv_ok, rdy_low}, 3'b011);
    @(negedge clk);
    chk(req_ready == 1'b1, {"R5 ready after done ", tag}, req_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0640));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && chan_strobe == 0 && !cyc_done && irq_pend == 0,
        "R1 reset outputs", {req_ready, chan_strobe, cyc_done, irq_pend}, 6'b100000);
    // R1: reset timing on both channels
    do_access(0, 0, "R1 primary reset", 0, 0);
    do_access(1, 1, "R1 R8 first secondary", 0, 0);

    // R2: every setup code on the primary channel
    cfg_write(0, 0, 0, 8'h21);
    for (int i = 0; i < 4; i++) begin
      cfg_write(0, 0, 1, {2'(i), 6'h3F});
      do_access(0, 0, "R2 code sweep", 0, 0);
    end
    // R3: zero active field, R4: maximal and minimal recovery
    cfg_write(0, 1, 0, 8'h0F);
    do_access(0, 1, "R3 active zero", 0, 0);
    cfg_write(0, 1, 0, 8'h10);
    do_access(0, 1, "R4 min recovery", 0, 0);
    // R6: independent primary drives
    cfg_write(0, 0, 0, 8'h12); cfg_write(0, 0, 1, 8'h40);
    cfg_write(0, 1, 0, 8'h83); cfg_write(0, 1, 1, 8'h80);
    do_access(0, 0, "R6 drive0", 0, 0);
    do_access(0, 1, "R6 drive1", 0, 0);
    do_access(0, 0, "R6 drive0 again", 0, 0);

    // R7: shared setup code written through drive 0, used by drive 1
    cfg_write(1, 0, 1, 8'h80);
    // R8 / R9 shared register behaviour
    cfg_write(1, 0, 0, 8'h21);
    cfg_write(1, 1, 0, 8'h33);
    do_access(1, 1, "R7 shared setup", 0, 0);
    do_access(1, 0, "R8 switch to drive0", 0, 0);
    cfg_write(1, 0, 0, 8'h45);
    do_access(1, 0, "R9 stale shared", 0, 0);
    do_access(1, 1, "R8 switch to drive1", 0, 0);
    do_access(1, 0, "R8 R9 reload after switch", 0, 0);

    // R10: mid-cycle writes on both channels
    do_access(0, 0, "R10 primary mid write", 1, 8'h5A);
    do_access(0, 0, "R10 primary after write", 0, 0);
    do_access(1, 1, "R10 secondary mid write", 1, 8'h62);
    do_access(1, 0, "R10 secondary switch", 0, 0);
    do_access(1, 1, "R10 secondary new value", 0, 0);

    // R11: interrupt flags
    dev_irq = 2'b01; @(negedge clk); dev_irq = 0;
    chk(irq_pend == 2'b01, "R11 set ch0", irq_pend, 1);
    repeat (3) @(negedge clk);
    chk(irq_pend == 2'b01, "R11 hold ch0", irq_pend, 1);
    irq_ack = 2'b01; @(negedge clk); irq_ack = 0;
    chk(irq_pend == 2'b00, "R11 ack ch0", irq_pend, 0);
    dev_irq = 2'b10; irq_ack = 2'b10; @(negedge clk); dev_irq = 0; irq_ack = 0;
    chk(irq_pend == 2'b10, "R11 set wins ch1", irq_pend, 2);
    irq_ack = 2'b10; @(negedge clk); irq_ack = 0;
    chk(irq_pend == 2'b00, "R11 ack ch1", irq_pend, 0);

    // random mix: R6 R7 R8
    for (int i = 0; i < 160; i++) begin
      if ($urandom % 3 == 0)
        cfg_write(1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom));
      do_access(1'($urandom), 1'($urandom), "R6 R7 R8 random", 0, 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule